// File: doc/BRIEF.md
# Iterative CORDIC Rotate/Vector Engine

This block is a shift-add CORDIC engine for a small coprocessor. It serves two commands on one shared datapath. The rotate command turns an angle into a sine and cosine pair with a fixed amplitude of 23167. The vector command turns an I/Q pair into its angle, which acts as an arctangent divide. Angles are signed and use 2^14 units per quarter turn, so 16384 is +pi/2.

A command is issued by pulsing `start` while the engine is idle. The `mode` input picks the command: 0 is rotate and 1 is vector. The engine captures the three register values and a 4-bit iteration count, then performs one micro-rotation per clock. When the last iteration finishes it writes the results back and raises `done` for one cycle. The rotate command starts from an internal seed on the cosine axis. The seed already divides out the growth of the chosen iteration count, so no multiplier is needed.

Top module: `cordic_engine`

## Requirements
- R1: A `start` seen while `busy` is low is accepted. It captures `mode` (0 = rotate, 1 = vector), `iter_cnt`, `i_in`, `q_in` and `ang_in`, and `busy` is high from the next cycle on.
- R2: With n = `iter_cnt`, where a count of 0 is treated as 1, `done` rises exactly n clock edges after the edge that accepted `start`. In the same cycle `busy` falls.
- R3: Rotate results: `i_out` lies within ((24000>>(n-1))+48) of 23167·sin(a·pi/32768), and `q_out` lies within the same bound of 23167·cos(a·pi/32768). Here a is the captured angle, limited to [-16384, 16384].
- R4: After a rotate command, `ang_out` equals the captured `ang_in`.
- R5: Vector result: `ang_out` lies within ((11000>>(n-1))+48) of atan2(I, Q)·32768/pi, where I and Q are the captured values and Q > 0.
- R6: After a vector command, `i_out` and `q_out` equal the captured `i_in` and `q_in`.
- R7: A `start` seen while `busy` is high is ignored. It does not change the timing, the results or the number of `done` pulses of the running command.
- R8: `done` lasts one cycle. While the engine is idle and no `start` arrives, the three outputs hold their values.
- R9: After reset, `busy`, `done`, `i_out`, `q_out` and `ang_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, taken only while idle |
| mode | input | 1 | 0 = rotate, 1 = vector |
| iter_cnt | input | 4 | Iteration count, 0 acts as 1 |
| i_in | input | DW | I register value (signed) |
| q_in | input | DW | Q register value (signed) |
| ang_in | input | DW | Angle register value (signed, 2^14 per quarter turn) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| i_out | output | DW | I register after the command |
| q_out | output | DW | Q register after the command |
| ang_out | output | DW | Angle register after the command |

## Verification
Rotate commands are driven with random angles across the full ±quarter-turn range. Directed cases cover 0, ±16384 and 8192, which show whether the sign handling and the seed are right on and between the axes. Sweeping the count from 1 to 15 with a narrowing tolerance separates a wrong arctangent entry or shift from ordinary truncation error. A count of 0 must match a count of 1 in both results and latency. Vector commands use random I values of either sign against a positive Q, plus the directed points 0, +45° and -45°. Each command checks its latency and that the register it should leave alone is untouched, and a second start during a busy command shows whether the engine restarts.

// File: rtl/cordic_engine.sv
module cordic_engine #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 mode,
  input  logic [3:0]           iter_cnt,
  input  logic signed [DW-1:0] i_in,
  input  logic signed [DW-1:0] q_in,
  input  logic signed [DW-1:0] ang_in,
  output logic                 busy,
  output logic                 done,
  output logic signed [DW-1:0] i_out,
  output logic signed [DW-1:0] q_out,
  output logic signed [DW-1:0] ang_out
);
  localparam int EXT = 2;
  localparam int EW  = DW + EXT;

  function automatic int atan_units(input logic [3:0] k);
    case (k)
      4'd0:  return 8192;
      4'd1:  return 4836;
      4'd2:  return 2555;
      4'd3:  return 1297;
      4'd4:  return 651;
      4'd5:  return 326;
      4'd6:  return 163;
      4'd7:  return 81;
      4'd8:  return 41;
      4'd9:  return 20;
      4'd10: return 10;
      4'd11: return 5;
      4'd12: return 3;
      4'd13: return 1;
      4'd14: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int seed_for(input logic [3:0] n);
    case (n)
      4'd0, 4'd1: return 16382;
      4'd2:  return 14652;
      4'd3:  return 14215;
      4'd4:  return 14105;
      4'd5:  return 14077;
      4'd6:  return 14071;
      4'd7:  return 14069;
      default: return 14068;
    endcase
  endfunction

  logic signed [EW-1:0] x, y, z;
  logic signed [EW-1:0] x_n, y_n, z_n, atn;
  logic [3:0] it, last;
  logic vec, cw;
  logic signed [DW-1:0] i_r, q_r, a_r;

  assign atn = EW'(atan_units(it));
  assign cw  = vec ? ~y[EW-1] : z[EW-1];
  assign y_n = cw ? y - (x >>> it) : y + (x >>> it);
  assign x_n = cw ? x + (y >>> it) : x - (y >>> it);
  assign z_n = cw ? z + atn : z - atn;

  assign i_out   = i_r;
  assign q_out   = q_r;
  assign ang_out = a_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      vec  <= 1'b0;
      it   <= '0;
      last <= '0;
      x    <= '0;
      y    <= '0;
      z    <= '0;
      i_r  <= '0;
      q_r  <= '0;
      a_r  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          it   <= '0;
          last <= (iter_cnt == 4'd0) ? 4'd0 : iter_cnt - 4'd1;
          vec  <= mode;
          i_r  <= i_in;
          q_r  <= q_in;
          a_r  <= ang_in;
          if (mode) begin
            y <= {{EXT{i_in[DW-1]}}, i_in};
            x <= {{EXT{q_in[DW-1]}}, q_in};
            z <= '0;
          end else begin
            y <= '0;
            x <= EW'(seed_for(iter_cnt));
            z <= {{EXT{ang_in[DW-1]}}, ang_in};
          end
        end
      end else begin
        x  <= x_n;
        y  <= y_n;
        z  <= z_n;
        it <= it + 4'd1;
        if (it == last) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (vec) begin
            a_r <= z_n[DW-1:0];
          end else begin
            i_r <= y_n[DW-1:0];
            q_r <= x_n[DW-1:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/cordic_engine_props.sv
module cordic_engine_props #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 mode,
  input logic [3:0]           iter_cnt,
  input logic                 busy,
  input logic                 done,
  input logic signed [DW-1:0] i_out,
  input logic signed [DW-1:0] q_out,
  input logic signed [DW-1:0] ang_out
);
  logic [4:0] n_eff, cyc;
  logic vec_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_eff <= 5'd1;
      cyc   <= '0;
      vec_l <= 1'b0;
    end else if (start && !busy) begin
      n_eff <= (iter_cnt == 4'd0) ? 5'd1 : {1'b0, iter_cnt};
      cyc   <= '0;
      vec_l <= mode;
    end else if (busy) begin
      cyc <= cyc + 5'd1;
    end
  end

  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r2_done_at_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc == n_eff) && !busy);

  a_r2_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cyc < n_eff));

  a_r4_rot_keeps_angle: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !vec_l) |-> (ang_out == $past(ang_out)));

  a_r6_vec_keeps_iq: assert property (@(posedge clk) disable iff (!rst_n)
    (done && vec_l) |-> (i_out == $past(i_out)) && (q_out == $past(q_out)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(i_out) && $stable(q_out) && $stable(ang_out)));
endmodule

bind cordic_engine cordic_engine_props #(.DW(DW)) u_props (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .iter_cnt(iter_cnt),
  .busy(busy), .done(done), .i_out(i_out), .q_out(q_out), .ang_out(ang_out)
);

// File: tb/cordic_engine_test.sv
module cordic_engine_test;
  localparam int DW = 16;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [3:0] iter_cnt = 4'd0;
  logic signed [DW-1:0] i_in = '0, q_in = '0, ang_in = '0;
  logic busy, done;
  logic signed [DW-1:0] i_out, q_out, ang_out;

  int checks = 0;
  int fails = 0;
  int lat;
  int done_seen;

  always #10 clk = ~clk;

  cordic_engine #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .iter_cnt(iter_cnt),
    .i_in(i_in), .q_in(q_in), .ang_in(ang_in),
    .busy(busy), .done(done), .i_out(i_out), .q_out(q_out), .ang_out(ang_out)
  );

  function automatic int n_of(input int c);
    return (c == 0) ? 1 : c;
  endfunction
  function automatic int tol_rot(input int c);
    return (24000 >> (n_of(c) - 1)) + 48;
  endfunction
  function automatic int tol_vec(input int c);
    return (11000 >> (n_of(c) - 1)) + 48;
  endfunction
  function automatic int exp_sin(input int a);
    return int'(23167.0 * $sin(a * PI / 32768.0));
  endfunction
  function automatic int exp_cos(input int a);
    return int'(23167.0 * $cos(a * PI / 32768.0));
  endfunction
  function automatic int exp_ang(input int i, input int q);
    return int'($atan2(real'(i), real'(q)) * 32768.0 / PI);
  endfunction

  task automatic chk(input string req, input int act, input int exp, input int tol);
    int d;
    d = act - exp;
    if (d < 0) d = -d;
    checks++;
    if (d > tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  task automatic issue(input logic m, input int c, input int iv, input int qv, input int av,
                       input bit extra);
    @(negedge clk);
    mode = m; iter_cnt = 4'(c);
    i_in = DW'(iv); q_in = DW'(qv); ang_in = DW'(av);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (extra) begin
      mode = ~m; iter_cnt = 4'd15;
      i_in = DW'(1234); q_in = DW'(5678); ang_in = DW'(-777);
    end else begin
      start = 1'b0;
    end
    lat = 0;
    done_seen = 0;
    while (!done && lat < 40) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
    end
    if (done) done_seen = 1;
  endtask

  task automatic run_rot(input int c, input int a, input bit extra);
    issue(1'b0, c, 111, 222, a, extra);
    chk("R2 latency", lat, n_of(c), 0);
    chk("R3 sin", int'(i_out), exp_sin(a), tol_rot(c));
    chk("R3 cos", int'(q_out), exp_cos(a), tol_rot(c));
    chk("R4 angle kept", int'(ang_out), a, 0);
  endtask

  task automatic run_vec(input int c, input int iv, input int qv, input bit extra);
    issue(1'b1, c, iv, qv, 999, extra);
    chk("R2 latency", lat, n_of(c), 0);
    chk("R5 angle", int'(ang_out), exp_ang(iv, qv), tol_vec(c));
    chk("R6 I kept", int'(i_out), iv, 0);
    chk("R6 Q kept", int'(q_out), qv, 0);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int si, sq, sa;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 busy", int'(busy), 0, 0);
    chk("R9 done", int'(done), 0, 0);
    chk("R9 i_out", int'(i_out), 0, 0);
    chk("R9 q_out", int'(q_out), 0, 0);
    chk("R9 ang_out", int'(ang_out), 0, 0);
    rst_n = 1'b1;

    // R1 busy rises after accept
    @(negedge clk);
    mode = 1'b0; iter_cnt = 4'd4; ang_in = '0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after accept", int'(busy), 1, 0);
    while (busy) @(negedge clk);

    // directed rotation corners, R3
    run_rot(15, 0, 1'b0);
    run_rot(15, 16384, 1'b0);
    run_rot(15, -16384, 1'b0);
    run_rot(15, 8192, 1'b0);
    run_rot(15, -5000, 1'b0);

    // count sweep, R2 and R3
    for (int c = 1; c <= 15; c++) run_rot(c, int'($urandom_range(32768)) - 16384, 1'b0);

    // count 0 behaves as 1, R2
    run_rot(1, 3000, 1'b0);
    si = int'(i_out); sq = int'(q_out);
    run_rot(0, 3000, 1'b0);
    chk("R2 count0 sin same as 1", int'(i_out), si, 0);
    chk("R2 count0 cos same as 1", int'(q_out), sq, 0);

    // directed vectoring, R5
    run_vec(15, 0, 10000, 1'b0);
    run_vec(15, 10000, 10000, 1'b0);
    run_vec(15, -10000, 10000, 1'b0);
    run_vec(15, 20000, 4000, 1'b0);
    run_vec(0, 5000, 8000, 1'b0);

    // random mix
    for (int k = 0; k < 60; k++) begin
      sa = int'($urandom_range(32768)) - 16384;
      run_rot(int'($urandom_range(15)), sa, 1'b0);
      si = int'($urandom_range(40000)) - 20000;
      sq = int'($urandom_range(16000)) + 4000;
      run_vec(int'($urandom_range(15)), si, sq, 1'b0);
    end

    // R7 start during busy ignored
    run_rot(6, 7000, 1'b1);
    chk("R7 one done", done_seen, 1, 0);
    run_vec(5, -3000, 9000, 1'b1);
    chk("R7 one done", done_seen, 1, 0);

    // R8 single-cycle done and hold while idle
    run_vec(10, 4000, 6000, 1'b0);
    si = int'(i_out); sq = int'(q_out); sa = int'(ang_out);
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0, 0);
    repeat (5) @(negedge clk);
    chk("R8 hold i", int'(i_out), si, 0);
    chk("R8 hold q", int'(q_out), sq, 0);
    chk("R8 hold angle", int'(ang_out), sa, 0);
    chk("R8 idle", int'(busy), 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule